// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Unit

This unit collects hardware event pulses into a sticky cause register, filters them through an enable mask and drives one registered interrupt line. Software reaches it over a small register bus with an address, a read strobe, a write strobe and write and read data. It can set or clear mask bits one by one, acknowledge causes by reading or by writing ones, program an auto-mask set and program an auto-clear set.

Acknowledge rules depend on a mode input. In legacy signalling, a read of the cause register always empties it. In message-signalled signalling, a read empties it only when the mask is all zeros or some enabled cause is pending. A message-sent pulse then drops the causes chosen by the auto-clear register. A control bit lets a cause read also drop the mask bits chosen by the auto-mask register. An event that arrives in the same cycle as any clear always survives.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset the cause, mask, auto-mask, auto-clear and control registers read as zero and `irq_o` is low.
- R2: An event pulse on `event_i[i]` sets cause bit i (i below 31). The bit stays set until a clear rule removes it.
- R3: A read at address 0 returns cause bits 30..0 in bits 30..0. Bit 31 reads 1 exactly when some cause bit is set while its mask bit is set.
- R4: `irq_o` is registered. It is high in the cycle after the registered cause AND mask is nonzero, and low in the cycle after it is zero.
- R5: A cause read returns the value from before any clearing. With `msg_mode_i` low (legacy), the same clock edge clears every cause bit.
- R6: With `msg_mode_i` high, a cause read clears every cause bit only if the mask is all zeros or bit 31 (R3) is 1. Otherwise the cause bits are kept.
- R7: A write at address 0 clears each cause bit i where write data bit i is 1. Data bit 31 has no effect.
- R8: A write at address 1 sets the mask bits where data holds 1. A write at address 2 clears them. Reads at address 1 or 2 return the mask, with bit 31 reading 0.
- R9: Address 3 holds the auto-mask set. Address 5 bit 0 is the auto-mask enable. While the enable is 1, a cause read clears the mask bits selected by the auto-mask set on the same edge.
- R10: Address 4 holds the auto-clear set. When `msg_sent_i` is high and `msg_mode_i` is high, the cause bits selected by it clear on that edge. With `msg_mode_i` low, `msg_sent_i` is ignored.
- R11: An event pulse in the same cycle as any cause clear leaves its bit set after that edge.
- R12: Addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W (3) | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | REG_W (32) | Write data |
| rdata_o | output | REG_W (32) | Read data for `addr_i`, combinational |
| event_i | input | REG_W-1 (31) | Event pulses, one per cause bit |
| msg_mode_i | input | 1 | 1 selects message-signalled, 0 selects legacy |
| msg_sent_i | input | 1 | Pulse: an interrupt message left |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench builds the unit with its default parameters: a 32-bit register width and a 3-bit address. With the 3-bit address the two unmapped addresses can be exercised, which the ignored-write and zero-read checks of R12 rely on. With all 31 cause bits live, random events can land on enabled and disabled bits at once, so both branches of the message-mode read rule and the event-versus-clear race are reached. Directed sequences hit these corners by name, and then several thousand random cycles mix reads, writes, modes and sent pulses.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    typedef enum logic [2:0] {
        ADR_CAUSE = 3'd0,
        ADR_MSET  = 3'd1,
        ADR_MCLR  = 3'd2,
        ADR_AMASK = 3'd3,
        ADR_ACLR  = 3'd4,
        ADR_CTRL  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic cause_rd;
        logic cause_wr;
        logic mset_wr;
        logic mclr_wr;
        logic amask_wr;
        logic aclr_wr;
        logic ctrl_wr;
    } strobe_t;

    function automatic logic addr_hit(input logic [2:0] a, input reg_addr_e r);
        return a == r;
    endfunction

endpackage

// File: rtl/irq_regdec.sv
module irq_regdec
    import irq_cause_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output strobe_t           stb_o
);
    logic       upper_zero;
    logic [2:0] low_addr;

    generate
        if (ADDR_W > 3) begin : g_wide
            assign upper_zero = (addr_i[ADDR_W-1:3] == '0);
        end else begin : g_narrow
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign low_addr = addr_i[2:0];

    always_comb begin
        stb_o          = '0;
        stb_o.cause_rd = rd_i & upper_zero & addr_hit(low_addr, ADR_CAUSE);
        stb_o.cause_wr = wr_i & upper_zero & addr_hit(low_addr, ADR_CAUSE);
        stb_o.mset_wr  = wr_i & upper_zero & addr_hit(low_addr, ADR_MSET);
        stb_o.mclr_wr  = wr_i & upper_zero & addr_hit(low_addr, ADR_MCLR);
        stb_o.amask_wr = wr_i & upper_zero & addr_hit(low_addr, ADR_AMASK);
        stb_o.aclr_wr  = wr_i & upper_zero & addr_hit(low_addr, ADR_ACLR);
        stb_o.ctrl_wr  = wr_i & upper_zero & addr_hit(low_addr, ADR_CTRL);
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_cause_pkg::*;
#(
    parameter int EV_W = 31
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  strobe_t         stb_i,
    input  logic [EV_W-1:0] wdata_i,
    input  logic            ctrl_bit_i,
    output logic [EV_W-1:0] mask_o,
    output logic [EV_W-1:0] amask_o,
    output logic [EV_W-1:0] aclr_o,
    output logic            amask_en_o
);
    logic [EV_W-1:0] mask_q, amask_q, aclr_q;
    logic            amask_en_q;
    logic [EV_W-1:0] mask_d;
    logic [EV_W-1:0] auto_drop;

    always_comb begin
        auto_drop = (stb_i.cause_rd && amask_en_q) ? amask_q : '0;
        mask_d    = mask_q;
        if (stb_i.mset_wr) mask_d = mask_d | wdata_i;
        if (stb_i.mclr_wr) mask_d = mask_d & ~wdata_i;
        mask_d = mask_d & ~auto_drop;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q     <= '0;
            amask_q    <= '0;
            aclr_q     <= '0;
            amask_en_q <= 1'b0;
        end else begin
            mask_q <= mask_d;
            if (stb_i.amask_wr) amask_q    <= wdata_i;
            if (stb_i.aclr_wr)  aclr_q     <= wdata_i;
            if (stb_i.ctrl_wr)  amask_en_q <= ctrl_bit_i;
        end
    end

    assign mask_o     = mask_q;
    assign amask_o    = amask_q;
    assign aclr_o     = aclr_q;
    assign amask_en_o = amask_en_q;

    // R8: mask set and mask clear writes
    assert_mask_set_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_i.mset_wr |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
    assert_mask_clear_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_i.mclr_wr |=> ((mask_q & $past(wdata_i)) == '0));
    // R9: auto-mask on cause read
    assert_auto_mask_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb_i.cause_rd && amask_en_q) |=> ((mask_q & $past(amask_q)) == '0));
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
    import irq_cause_pkg::*;
#(
    parameter int EV_W = 31
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  strobe_t         stb_i,
    input  logic [EV_W-1:0] wdata_i,
    input  logic [EV_W-1:0] event_i,
    input  logic            msg_mode_i,
    input  logic            msg_sent_i,
    input  logic [EV_W-1:0] mask_i,
    input  logic [EV_W-1:0] aclr_i,
    output logic [EV_W-1:0] cause_o,
    output logic            summary_o
);
    logic [EV_W-1:0] cause_q;
    logic [EV_W-1:0] cause_d;
    logic [EV_W-1:0] clr_vec;
    logic            pending;
    logic            read_flush;

    assign pending    = |(cause_q & mask_i);
    assign read_flush = stb_i.cause_rd &
                        (~msg_mode_i | (mask_i == '0) | pending);

    always_comb begin
        clr_vec = '0;
        if (read_flush)               clr_vec = '1;
        if (stb_i.cause_wr)           clr_vec = clr_vec | wdata_i;
        if (msg_mode_i && msg_sent_i) clr_vec = clr_vec | aclr_i;
    end

    genvar i;
    generate
        for (i = 0; i < EV_W; i++) begin : g_bit
            assign cause_d[i] = event_i[i] | (cause_q[i] & ~clr_vec[i]);
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) cause_q <= '0;
        else       cause_q <= cause_d;
    end

    assign cause_o   = cause_q;
    assign summary_o = pending;

    // R2 / R11: an event always lands, whatever clears the same cycle
    assert_event_lands_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (event_i != '0) |=> ((cause_q & $past(event_i)) == $past(event_i)));
    // R5: legacy read empties the register
    assert_legacy_flush_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb_i.cause_rd && !msg_mode_i && event_i == '0) |=> (cause_q == '0));
    // R6: message-mode read with masked-only causes keeps them
    assert_msg_keep_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb_i.cause_rd && msg_mode_i && !pending && mask_i != '0 &&
         !stb_i.cause_wr && !msg_sent_i) |=> (cause_q == $past(cause_q | event_i)));
    // R10: message-sent auto-clear
    assert_auto_clear_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (msg_mode_i && msg_sent_i && event_i == '0) |=> ((cause_q & $past(aclr_i)) == '0));
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
    import irq_cause_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic [REG_W-2:0]  event_i,
    input  logic              msg_mode_i,
    input  logic              msg_sent_i,
    output logic              irq_o
);
    localparam int EV_W = REG_W - 1;

    strobe_t         stb;
    logic [EV_W-1:0] cause, mask, amask, aclr;
    logic            amask_en;
    logic            summary;
    logic            irq_q;

    irq_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (addr_i),
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .stb_o  (stb)
    );

    irq_mask_bank #(.EV_W(EV_W)) u_mask (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .stb_i      (stb),
        .wdata_i    (wdata_i[EV_W-1:0]),
        .ctrl_bit_i (wdata_i[0]),
        .mask_o     (mask),
        .amask_o    (amask),
        .aclr_o     (aclr),
        .amask_en_o (amask_en)
    );

    irq_cause_reg #(.EV_W(EV_W)) u_cause (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .stb_i      (stb),
        .wdata_i    (wdata_i[EV_W-1:0]),
        .event_i    (event_i),
        .msg_mode_i (msg_mode_i),
        .msg_sent_i (msg_sent_i),
        .mask_i     (mask),
        .aclr_i     (aclr),
        .cause_o    (cause),
        .summary_o  (summary)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i < ADDR_W'(6)) begin
            unique case (addr_i[2:0])
                ADR_CAUSE: rdata_o = {summary, cause};
                ADR_MSET,
                ADR_MCLR:  rdata_o = {1'b0, mask};
                ADR_AMASK: rdata_o = {1'b0, amask};
                ADR_ACLR:  rdata_o = {1'b0, aclr};
                ADR_CTRL:  rdata_o = {{(REG_W-1){1'b0}}, amask_en};
                default:   rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) irq_q <= 1'b0;
        else       irq_q <= |(cause & mask);
    end

    assign irq_o = irq_q;

    // R4: interrupt line follows the pending state one cycle later
    assert_irq_follows_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (irq_o == $past(summary)));
    // R12: writes to unmapped addresses leave the mask alone
    assert_unmapped_quiet_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && addr_i >= ADDR_W'(6) && !(rd_i && addr_i == '0)) |=> $stable(mask));
endmodule

// File: tb/irq_cause_unit_test.sv
module irq_cause_unit_test;
    localparam int REG_W = 32;
    localparam int ADDR_W = 3;
    localparam int EV_W = REG_W - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd = 1'b0, wr = 1'b0;
    logic [REG_W-1:0]  wdata = '0;
    logic [REG_W-1:0]  rdata;
    logic [EV_W-1:0]   ev = '0;
    logic              mode = 1'b0, sent = 1'b0;
    logic              irq;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    logic [EV_W-1:0] m_cause = '0, m_mask = '0, m_am = '0, m_ac = '0;
    logic            m_en = 1'b0, m_irq = 1'b0;

    always #5 clk = ~clk;

    irq_cause_unit #(.REG_W(REG_W), .ADDR_W(ADDR_W)) uut (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata), .event_i(ev),
        .msg_mode_i(mode), .msg_sent_i(sent), .irq_o(irq)
    );

    function automatic logic [REG_W-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:       return {|(m_cause & m_mask), m_cause};
            3'd1, 3'd2: return {1'b0, m_mask};
            3'd3:       return {1'b0, m_am};
            3'd4:       return {1'b0, m_ac};
            3'd5:       return {31'd0, m_en};
            default:    return '0;
        endcase
    endfunction

    task automatic model_edge(input logic [2:0] a, input logic r, input logic w,
                              input logic [REG_W-1:0] d, input logic [EV_W-1:0] e,
                              input logic md, input logic s);
        logic [EV_W-1:0] clr;
        logic            nirq;
        nirq = |(m_cause & m_mask);
        clr  = '0;
        if (r && a == 3'd0 && (!md || m_mask == '0 || (m_cause & m_mask) != '0)) clr = '1;
        if (w && a == 3'd0) clr = clr | d[EV_W-1:0];
        if (md && s) clr = clr | m_ac;
        if (r && a == 3'd0 && m_en) m_mask = m_mask & ~m_am;
        m_cause = (m_cause & ~clr) | e;
        if (w && a == 3'd1) m_mask = m_mask | d[EV_W-1:0];
        if (w && a == 3'd2) m_mask = m_mask & ~d[EV_W-1:0];
        if (w && a == 3'd3) m_am = d[EV_W-1:0];
        if (w && a == 3'd4) m_ac = d[EV_W-1:0];
        if (w && a == 3'd5) m_en = d[0];
        m_irq = nirq;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [REG_W-1:0] got, input logic [REG_W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %08h expected %08h", tag, what, got, exp);
        end
    endtask

    task automatic step(input string tag, input logic [2:0] a, input logic r,
                        input logic w, input logic [REG_W-1:0] d,
                        input logic [EV_W-1:0] e, input logic md, input logic s);
        @(negedge clk);
        check(tag, "irq_o", {31'd0, irq}, {31'd0, m_irq});
        addr = a; rd = r; wr = w; wdata = d; ev = e; mode = md; sent = s;
        #1;
        if (r) check(tag, "rdata_o", rdata, model_read(a));
        @(posedge clk);
        model_edge(a, r, w, d, e, md, s);
    endtask

    task automatic idle(input string tag, input logic md);
        step(tag, 3'd0, 1'b0, 1'b0, '0, '0, md, 1'b0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        for (int a = 0; a < 6; a++) step("R1", 3'(a), 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);

        // R2 / R5: event sets a sticky bit, legacy read returns and empties
        step("R2", 3'd0, 1'b0, 1'b0, '0, 31'h8, 1'b0, 1'b0);
        idle("R2", 1'b0);
        step("R5", 3'd0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
        step("R5", 3'd0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);

        // R8: mask set, clear, readback
        step("R8", 3'd1, 1'b0, 1'b1, 32'h0000_0028, '0, 1'b0, 1'b0);
        step("R8", 3'd1, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
        step("R8", 3'd2, 1'b0, 1'b1, 32'h8000_0020, '0, 1'b0, 1'b0);
        step("R8", 3'd2, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);

        // R3 / R4: enabled cause shows in bit 31 and raises irq a cycle later
        step("R3", 3'd0, 1'b0, 1'b0, '0, 31'h8, 1'b0, 1'b0);
        idle("R4", 1'b0);
        idle("R4", 1'b0);
        step("R3", 3'd0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
        idle("R4", 1'b0);
        idle("R4", 1'b0);

        // R6: message-mode read keeps masked-only causes, flushes with zero mask
        step("R6", 3'd0, 1'b0, 1'b0, '0, 31'h20, 1'b1, 1'b0);
        step("R6", 3'd0, 1'b1, 1'b0, '0, '0, 1'b1, 1'b0);
        step("R6", 3'd0, 1'b1, 1'b0, '0, '0, 1'b1, 1'b0);
        step("R6", 3'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, '0, 1'b1, 1'b0);
        step("R6", 3'd0, 1'b1, 1'b0, '0, '0, 1'b1, 1'b0);
        step("R6", 3'd0, 1'b1, 1'b0, '0, '0, 1'b1, 1'b0);

        // R7: write-one-to-clear
        step("R7", 3'd0, 1'b0, 1'b0, '0, 31'h0F, 1'b1, 1'b0);
        step("R7", 3'd0, 1'b0, 1'b1, 32'h8000_0005, '0, 1'b1, 1'b0);
        step("R7", 3'd0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);

        // R9: auto-mask on read
        step("R9", 3'd1, 1'b0, 1'b1, 32'h0000_00FF, '0, 1'b0, 1'b0);
        step("R9", 3'd3, 1'b0, 1'b1, 32'h0000_000F, '0, 1'b0, 1'b0);
        step("R9", 3'd5, 1'b0, 1'b1, 32'h0000_0001, '0, 1'b0, 1'b0);
        step("R9", 3'd5, 1'b1, 1'b0, '0, 31'h01, 1'b0, 1'b0);
        step("R9", 3'd0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
        step("R9", 3'd1, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
        step("R9", 3'd5, 1'b0, 1'b1, 32'h0, '0, 1'b0, 1'b0);

        // R10: auto-clear on message sent, ignored in legacy mode
        step("R10", 3'd4, 1'b0, 1'b1, 32'h0000_0003, '0, 1'b0, 1'b0);
        step("R10", 3'd0, 1'b0, 1'b0, '0, 31'h07, 1'b0, 1'b0);
        step("R10", 3'd0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1);
        step("R10", 3'd0, 1'b1, 1'b0, '0, '0, 1'b1, 1'b0);
        step("R10", 3'd0, 1'b0, 1'b0, '0, '0, 1'b1, 1'b1);
        step("R10", 3'd0, 1'b1, 1'b0, '0, '0, 1'b1, 1'b0);

        // R11: events beat same-cycle clears
        step("R11", 3'd0, 1'b0, 1'b0, '0, 31'h02, 1'b1, 1'b1);
        step("R11", 3'd0, 1'b1, 1'b0, '0, '0, 1'b1, 1'b0);
        step("R11", 3'd0, 1'b1, 1'b0, '0, 31'h10, 1'b0, 1'b0);
        step("R11", 3'd0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
        step("R11", 3'd0, 1'b0, 1'b1, 32'h0000_0040, 31'h40, 1'b0, 1'b0);
        step("R11", 3'd0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);

        // R12: unmapped addresses
        step("R12", 3'd6, 1'b0, 1'b1, 32'hFFFF_FFFF, '0, 1'b0, 1'b0);
        step("R12", 3'd7, 1'b1, 1'b1, 32'hFFFF_FFFF, '0, 1'b0, 1'b0);
        step("R12", 3'd6, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
        for (int a = 1; a < 6; a++) step("R12", 3'(a), 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic [2:0]       ra;
            logic [EV_W-1:0]  re;
            logic [REG_W-1:0] rw;
            ra = 3'($urandom_range(0, 7));
            re = ($urandom_range(0, 3) == 0) ? EV_W'($urandom) & EV_W'($urandom) : '0;
            rw = ($urandom_range(0, 1) == 0) ? $urandom & $urandom : $urandom;
            step("RAND", ra, 1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0),
                 rw, re, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
        end
        idle("RAND", 1'b0);
        finish_run();
    end
endmodule